// File: doc/BRIEF.md
# Interleaving Block Scheduler for a Chained Hash Engine

This block sits in front of a multi-cycle hash engine that digests packet payloads as a chain of 64-byte blocks. Inside one packet every block depends on the digest state left by the block before it. A block may therefore enter the engine only after its predecessor has come back. Blocks of different packets share no state. The scheduler keeps several packets resident at once and feeds the engine from whichever of them is ready, so that the engine's latency is hidden behind work from other packets.

Packets arrive on a valid/ready ingest port. Each one carries an identifier, a sequence number and the number of blocks it holds, which must be at least one. Every issued block names its packet slot (the tag), the packet identifier and the block index. The engine returns the tag on the completion port. When the final block of a packet returns, the scheduler reports the packet identifier and its sequence number on the done port and releases the slot. Short packets can overtake long ones. A later stage uses the sequence number to put packets back in arrival order.

Top module: `blk_ilv_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `iss_vld` and `done_vld` are 0 and `in_rdy` is 1.
- R2: `in_rdy` is 1 exactly when at least one of the NSLOT slots is free. A packet is taken on a clock edge where `in_vld` and `in_rdy` are both 1, and it goes into the lowest-numbered free slot. That slot number is the tag used on the issue and completion ports.
- R3: The blocks of a packet are issued in index order 0, 1, ..., count-1, and each index is issued exactly once. Every issue carries the packet's identifier.
- R4: No block of a packet is issued while another block of the same packet is in flight, meaning it has been issued and has not yet completed.
- R5: At most one block is issued per cycle. If, after a clock edge, some resident packet has unissued blocks and none in flight, a block is issued on the next edge. Otherwise `iss_vld` stays 0.
- R6: When several slots are ready, the grant goes to the first ready slot found by searching upward, with wrap-around, from the slot just after the one granted most recently.
- R7: A completion for the last block of a packet raises `done_vld` on the same clock edge that captures it, together with that packet's identifier and sequence number, and frees the slot on that edge. `done_vld` is reported exactly once per packet.
- R8: Packets finish in completion order, not arrival order. A one-block packet that arrives after a long packet reports done before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Ingest request valid |
| in_rdy | output | 1 | A free slot exists |
| in_id | input | ID_W | Packet identifier |
| in_seq | input | SEQ_W | Packet sequence number |
| in_nblk | input | CNT_W | Number of 64-byte blocks in the packet (at least 1) |
| iss_vld | output | 1 | Block issue to the engine |
| iss_tag | output | log2(NSLOT) | Slot of the issued block |
| iss_id | output | ID_W | Packet identifier of the issued block |
| iss_blk | output | CNT_W | Block index within its packet |
| cmp_vld | input | 1 | Engine completion valid |
| cmp_tag | input | log2(NSLOT) | Slot whose block completed |
| done_vld | output | 1 | Packet finished |
| done_id | output | ID_W | Identifier of the finished packet |
| done_seq | output | SEQ_W | Sequence number of the finished packet |

## Verification
A directed run uses zero engine latency and three packets that arrive on consecutive cycles. This sets up cycles in which two slots are ready together. A scheduler that always picks the lowest ready slot would issue packet 0 twice in a row instead of rotating 0, 1, 2. A long packet followed by a one-block packet shows whether done follows completion order. A design that reports done in arrival order, or on the wrong block, gets the identifier order or the sequence number wrong. A burst under a slow engine fills every slot and checks `in_rdy` on each cycle. This catches a design that overwrites a resident packet, or that holds off ingest for an extra cycle after a slot frees. Random traffic under several engine latencies checks every issue for block order and for a second block issued while one is in flight. It also checks that the engine is never left idle while a ready block waits.

// File: rtl/blk_ilv_pkg.sv
package blk_ilv_pkg;
    parameter int ID_W  = 8;
    parameter int SEQ_W = 8;
    parameter int CNT_W = 4;

    typedef struct packed {
        logic             vld;
        logic             infl;
        logic [CNT_W-1:0] rem;
        logic [CNT_W-1:0] idx;
        logic [ID_W-1:0]  id;
        logic [SEQ_W-1:0] seq;
    } slot_t;
endpackage

// File: rtl/blk_rr_pick.sv
module blk_rr_pick #(
    parameter int N  = 4,
    parameter int SW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [SW-1:0] ptr,
    output logic          gnt_vld,
    output logic [SW-1:0] gnt_idx
);
    // scan from the far end so the nearest ready slot after ptr wins
    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int off = N - 1; off >= 0; off--) begin
            automatic int k = int'(ptr) + off;
            if (k >= N) k = k - N;
            if (req[k]) begin
                gnt_vld = 1'b1;
                gnt_idx = SW'(k);
            end
        end
    end
endmodule

// File: rtl/blk_free_pick.sv
module blk_free_pick #(
    parameter int N  = 4,
    parameter int SW = $clog2(N)
) (
    input  logic [N-1:0]  free,
    output logic          any,
    output logic [SW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free[i]) begin
                any = 1'b1;
                idx = SW'(i);
            end
        end
    end
endmodule

// File: rtl/blk_ilv_sched.sv
module blk_ilv_sched
    import blk_ilv_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int SW    = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    output logic             in_rdy,
    input  logic [ID_W-1:0]  in_id,
    input  logic [SEQ_W-1:0] in_seq,
    input  logic [CNT_W-1:0] in_nblk,
    output logic             iss_vld,
    output logic [SW-1:0]    iss_tag,
    output logic [ID_W-1:0]  iss_id,
    output logic [CNT_W-1:0] iss_blk,
    input  logic             cmp_vld,
    input  logic [SW-1:0]    cmp_tag,
    output logic             done_vld,
    output logic [ID_W-1:0]  done_id,
    output logic [SEQ_W-1:0] done_seq
);
    typedef struct packed {
        slot_t [NSLOT-1:0] slot;
        logic [SW-1:0]     ptr;
        logic              iss_vld;
        logic [SW-1:0]     iss_tag;
        logic [ID_W-1:0]   iss_id;
        logic [CNT_W-1:0]  iss_blk;
        logic              done_vld;
        logic [ID_W-1:0]   done_id;
        logic [SEQ_W-1:0]  done_seq;
    } st_t;

    st_t cq, cd;

    logic [NSLOT-1:0] elig, free;
    logic             gnt_vld, free_any;
    logic [SW-1:0]    gnt_idx, free_idx;

    for (genvar g = 0; g < NSLOT; g++) begin : g_flags
        assign elig[g] = cq.slot[g].vld && !cq.slot[g].infl && (cq.slot[g].rem != '0);
        assign free[g] = !cq.slot[g].vld;
    end

    blk_rr_pick #(.N(NSLOT), .SW(SW)) u_rr (
        .req(elig), .ptr(cq.ptr), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
    );

    blk_free_pick #(.N(NSLOT), .SW(SW)) u_free (
        .free(free), .any(free_any), .idx(free_idx)
    );

    assign in_rdy = free_any;

    always_comb begin
        cd          = cq;
        cd.iss_vld  = 1'b0;
        cd.done_vld = 1'b0;
        // completion: the engine has returned a block for this slot
        if (cmp_vld) begin
            cd.slot[cmp_tag].infl = 1'b0;
            if (cq.slot[cmp_tag].rem == '0) begin
                cd.slot[cmp_tag].vld = 1'b0;
                cd.done_vld          = 1'b1;
                cd.done_id           = cq.slot[cmp_tag].id;
                cd.done_seq          = cq.slot[cmp_tag].seq;
            end
        end
        // issue: one block per cycle from the granted slot
        if (gnt_vld) begin
            cd.slot[gnt_idx].infl = 1'b1;
            cd.slot[gnt_idx].rem  = cq.slot[gnt_idx].rem - 1'b1;
            cd.slot[gnt_idx].idx  = cq.slot[gnt_idx].idx + 1'b1;
            cd.iss_vld            = 1'b1;
            cd.iss_tag            = gnt_idx;
            cd.iss_id             = cq.slot[gnt_idx].id;
            cd.iss_blk            = cq.slot[gnt_idx].idx;
            cd.ptr                = (gnt_idx == SW'(NSLOT - 1)) ? '0 : gnt_idx + 1'b1;
        end
        // ingest into the lowest free slot
        if (in_vld && free_any) begin
            cd.slot[free_idx].vld  = 1'b1;
            cd.slot[free_idx].infl = 1'b0;
            cd.slot[free_idx].rem  = in_nblk;
            cd.slot[free_idx].idx  = '0;
            cd.slot[free_idx].id   = in_id;
            cd.slot[free_idx].seq  = in_seq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cq <= '0;
        else        cq <= cd;
    end

    assign iss_vld  = cq.iss_vld;
    assign iss_tag  = cq.iss_tag;
    assign iss_id   = cq.iss_id;
    assign iss_blk  = cq.iss_blk;
    assign done_vld = cq.done_vld;
    assign done_id  = cq.done_id;
    assign done_seq = cq.done_seq;

    // R4
    cmp_infl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_vld |-> cq.slot[cmp_tag].infl);

    // R7
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_vld |-> $past(cmp_vld));

    // R2
    ingest_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_rdy) |=> cq.slot[$past(free_idx)].vld);

    // R5
    iss_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> $past(|elig));
endmodule

// File: tb/sim_blk_ilv_sched.sv
module sim_blk_ilv_sched;
    import blk_ilv_pkg::*;
    localparam int NS = 4;
    localparam int SW = 2;
    localparam int NP = 256;

    logic clk = 1'b0;
    logic rst_n;
    logic in_vld, in_rdy;
    logic [ID_W-1:0] in_id;
    logic [SEQ_W-1:0] in_seq;
    logic [CNT_W-1:0] in_nblk;
    logic iss_vld;
    logic [SW-1:0] iss_tag;
    logic [ID_W-1:0] iss_id;
    logic [CNT_W-1:0] iss_blk;
    logic cmp_vld;
    logic [SW-1:0] cmp_tag;
    logic done_vld;
    logic [ID_W-1:0] done_id;
    logic [SEQ_W-1:0] done_seq;

    always #2.5 clk = ~clk;

    blk_ilv_sched #(.NSLOT(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy),
        .in_id(in_id), .in_seq(in_seq), .in_nblk(in_nblk),
        .iss_vld(iss_vld), .iss_tag(iss_tag), .iss_id(iss_id), .iss_blk(iss_blk),
        .cmp_vld(cmp_vld), .cmp_tag(cmp_tag),
        .done_vld(done_vld), .done_id(done_id), .done_seq(done_seq)
    );

    int total = 0, bad = 0, cyc = 0;
    bit wd = 0;
    int p_nblk[NP], p_seq[NP], p_nxt[NP], p_cmp[NP];
    bit p_acc[NP], p_done[NP], p_infl[NP];
    int n_plan = 0, nxt_in = 0, done_cnt = 0, occ = 0;
    int lat = 0, pct = 100;
    bit acc_pend = 0, exp_iss = 0, saw_full = 0;
    bit due_v[32];
    logic [SW-1:0] due_tag[32];
    int due_pid[32];
    int cmp_pid = 0;
    int iss_log[64], n_iss_log = 0;
    int done_log[64], n_done_log = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    task automatic add_pkt(input int nb, input int sq);
        p_nblk[n_plan] = nb; p_seq[n_plan] = sq;
        p_nxt[n_plan] = 0; p_cmp[n_plan] = 0;
        p_acc[n_plan] = 0; p_done[n_plan] = 0; p_infl[n_plan] = 0;
        n_plan++;
    endtask

    function automatic bit any_ready();
        for (int i = 0; i < n_plan; i++)
            if (p_acc[i] && !p_done[i] && !p_infl[i] && p_nxt[i] < p_nblk[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step();
        int pid;
        cyc++;
        if (acc_pend) begin
            p_acc[nxt_in] = 1; occ++; nxt_in++;
        end
        if (cmp_vld) begin
            p_infl[cmp_pid] = 0; p_cmp[cmp_pid]++;
        end
        // R5: an issue appears exactly when a block was ready one cycle earlier
        chk(iss_vld == exp_iss, "R5", int'(iss_vld), int'(exp_iss));
        if (iss_vld) begin
            pid = int'(iss_id);
            chk(p_acc[pid] && !p_done[pid], "R3", int'(p_acc[pid]), 1);
            chk(!p_infl[pid], "R4", int'(p_infl[pid]), 0);
            chk(int'(iss_blk) == p_nxt[pid], "R3", int'(iss_blk), p_nxt[pid]);
            p_infl[pid] = 1; p_nxt[pid]++;
            due_v[(cyc + lat) % 32] = 1;
            due_tag[(cyc + lat) % 32] = iss_tag;
            due_pid[(cyc + lat) % 32] = pid;
            if (n_iss_log < 64) begin iss_log[n_iss_log] = pid; n_iss_log++; end
        end
        if (done_vld) begin
            pid = int'(done_id);
            chk(!p_done[pid] && p_cmp[pid] == p_nblk[pid], "R7", p_cmp[pid], p_nblk[pid]);
            chk(int'(done_seq) == p_seq[pid], "R7", int'(done_seq), p_seq[pid]);
            p_done[pid] = 1; occ--; done_cnt++;
            if (n_done_log < 64) begin done_log[n_done_log] = pid; n_done_log++; end
        end
        // R2: ready exactly when a slot is free
        chk(in_rdy == (occ < NS), "R2", int'(in_rdy), int'(occ < NS));
        if (!in_rdy) saw_full = 1;
        exp_iss = any_ready();
        if (due_v[cyc % 32]) begin
            cmp_vld = 1; cmp_tag = due_tag[cyc % 32]; cmp_pid = due_pid[cyc % 32];
            due_v[cyc % 32] = 0;
        end else begin
            cmp_vld = 0;
        end
        if (nxt_in < n_plan && int'($urandom_range(99)) < pct) begin
            in_vld = 1; in_id = ID_W'(nxt_in);
            in_seq = SEQ_W'(p_seq[nxt_in]); in_nblk = CNT_W'(p_nblk[nxt_in]);
        end else begin
            in_vld = 0;
        end
        acc_pend = in_vld && in_rdy;
    endtask

    task automatic run_phase(input int l, input int p);
        lat = l; pct = p; n_iss_log = 0; n_done_log = 0;
        while (!wd && done_cnt < n_plan) begin
            @(negedge clk);
            step();
            if (cyc > 150000) wd = 1;
        end
    endtask

    initial begin
        int base;
        void'($urandom(32'd7));
        for (int i = 0; i < 32; i++) due_v[i] = 0;
        rst_n = 0; in_vld = 0; cmp_vld = 0; cmp_tag = '0;
        in_id = '0; in_seq = '0; in_nblk = '0;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk(!iss_vld && !done_vld && in_rdy, "R1", int'(iss_vld) + int'(done_vld), 0);
        rst_n = 1;
        @(negedge clk);
        chk(!iss_vld && !done_vld && in_rdy, "R1", int'(iss_vld) + int'(done_vld), 0);

        // R6: three packets, zero engine latency, round-robin rotation
        base = n_plan;
        for (int i = 0; i < 3; i++) add_pkt(3, 16 + i);
        run_phase(0, 100);
        for (int i = 0; i < 9; i++)
            chk(i < n_iss_log && iss_log[i] == base + (i % 3), "R6",
                (i < n_iss_log) ? iss_log[i] : -1, base + (i % 3));

        // R8: long packet then one-block packet
        base = n_plan;
        add_pkt(6, 200); add_pkt(1, 201);
        run_phase(3, 100);
        chk(n_done_log == 2 && done_log[0] == base + 1, "R8", done_log[0], base + 1);
        chk(n_done_log == 2 && done_log[1] == base, "R8", done_log[1], base);

        // R2: slow engine fills every slot
        saw_full = 0;
        for (int i = 0; i < 6; i++) add_pkt(2, 40 + i);
        run_phase(10, 100);
        chk(saw_full, "R2", int'(saw_full), 1);

        // random traffic under several latencies
        for (int ph = 0; ph < 3; ph++) begin
            for (int i = 0; i < 40; i++)
                add_pkt(int'($urandom_range(8, 1)), int'($urandom_range(255)));
            run_phase(ph * 3 + int'($urandom_range(1)), 30 + ph * 30);
        end

        // R3: every block of every packet issued exactly once
        for (int i = 0; i < n_plan; i++)
            if (p_nxt[i] != p_nblk[i] || !p_done[i])
                chk(0, "R3", p_nxt[i], p_nblk[i]);
        chk(done_cnt == n_plan, "R7", done_cnt, n_plan);
        if (wd) chk(0, "WATCHDOG", cyc, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule